// File: doc/BRIEF.md
# Programmable prescaled timer

This peripheral sits on a small processor's byte bus and gives it two time bases. A divider byte advances at a fixed fraction of the system clock and never stops. A timer counter byte advances at one of four selectable rates while enabled. When the timer counter passes its top value it is reloaded from a software-set modulo byte, and a sticky interrupt request is raised.

Software reaches four byte registers through an address, a write strobe, write data and a combinational read data port. It acknowledges the interrupt through a single-cycle clear input. Every register resets to zero, and the timer starts disabled with the slowest rate selected.

Top module: `prescaled_timer`

## Requirements
- R1: The divider register (address 0xFF04) increases by one after every 256 system clock cycles, whether or not the timer is enabled.
- R2: Control bits [1:0] set the timer tick period in system clocks: code 0 = 1024, code 1 = 16, code 2 = 64, code 3 = 256. The first tick after the period is set arrives that many cycles after the control write.
- R3: A tick while the counter (address 0xFF05) holds 0xFF loads the counter with the modulo register (address 0xFF06) and sets the interrupt flag.
- R4: A tick while the counter is below 0xFF adds one to it.
- R5: After reset the divider, counter, modulo and control fields are zero, the interrupt output is low, and the timer is disabled with period code 0.
- R6: The interrupt output stays high until irq_clr_i is high for a cycle. When an overflow and a clear fall in the same cycle, the output stays high.
- R7: Control bit 2 is the timer enable. While it is 0, the counter and its period accumulator hold.
- R8: Reads return the divider at 0xFF04, the counter at 0xFF05, the modulo at 0xFF06 and the control register at 0xFF07. Control bits [7:3] read as 1. Any other address reads 0xFF, and writes to it change nothing.
- R9: A write to 0xFF05 or 0xFF06 stores the byte. A write of any value to 0xFF04 sets the divider and its cycle accumulator to zero. A counter write wins over a tick in the same cycle.
- R10: A control write that changes bits [1:0] restarts the period accumulator. A control write that keeps them leaves the accumulator running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 16 | Byte address |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| irq_o | output | 1 | Sticky overflow interrupt request |

## Verification
The assertions check several rules on every cycle: the flag holds until cleared and drops after a clear with no overflow, an overflow reloads the modulo value, a tick below the top adds exactly one, a disabled timer holds its count, and the read path returns 0xFF for unmapped addresses and ones in the upper control bits. The cycle-exact tick spacing of all four periods, the 256-cycle divider step and its clear, and the accumulator restart on a period change cover hundreds of cycles. Only the bench's timed scenarios can show these. The bench scenarios also cover the clear that coincides with an overflow.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int DIV_ACC_W = 8;    // divider steps once per 2**DIV_ACC_W cycles
    localparam int TMR_ACC_W = 10;   // wide enough for the longest period
    localparam int CTRL_W    = 3;    // enable + two-bit rate code

    typedef logic [DATA_W-1:0] byte_t;

    // Last accumulator value before a tick, i.e. period - 1.
    function automatic logic [TMR_ACC_W-1:0] period_last(input logic [1:0] code);
        logic [TMR_ACC_W-1:0] r;
        case (code)
            2'd0:    r = TMR_ACC_W'(1023);
            2'd1:    r = TMR_ACC_W'(15);
            2'd2:    r = TMR_ACC_W'(63);
            default: r = TMR_ACC_W'(255);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ptmr_divider.sv
module ptmr_divider
    import ptmr_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  clear_i,
    output byte_t div_o
);
    typedef struct packed {
        logic [DIV_ACC_W-1:0] acc;
        byte_t                div;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.acc = '0;
            st_d.div = '0;
        end else begin
            st_d.acc = st_q.acc + 1'b1;
            if (&st_q.acc) begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.div;
endmodule

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen
    import ptmr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [1:0] code_i,
    input  logic       restart_i,
    output logic       tick_o
);
    typedef struct packed {
        logic [TMR_ACC_W-1:0] acc;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        hit  = en_i && (st_q.acc == period_last(code_i));
        st_d = st_q;
        if (restart_i || hit) begin
            st_d.acc = '0;
        end else if (en_i) begin
            st_d.acc = st_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = hit;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import ptmr_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'hFF04
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [15:0] bus_addr_i,
    input  logic        bus_we_i,
    input  logic [7:0]  bus_wdata_i,
    output logic [7:0]  bus_rdata_o,
    input  logic        irq_clr_i,
    output logic        irq_o
);
    localparam logic [15:0] A_DIV  = BASE_ADDR;
    localparam logic [15:0] A_CNT  = BASE_ADDR + 16'd1;
    localparam logic [15:0] A_MOD  = BASE_ADDR + 16'd2;
    localparam logic [15:0] A_CTRL = BASE_ADDR + 16'd3;
    localparam int          PAD_W  = DATA_W - CTRL_W;

    typedef struct packed {
        byte_t             cnt;
        byte_t             modv;
        logic [CTRL_W-1:0] ctrl;
        logic              flag;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic  wr_div, wr_cnt, wr_mod, wr_ctrl;
    logic  tick_w, ovf_w, restart_w;
    byte_t div_w;

    assign wr_div    = bus_we_i && (bus_addr_i == A_DIV);
    assign wr_cnt    = bus_we_i && (bus_addr_i == A_CNT);
    assign wr_mod    = bus_we_i && (bus_addr_i == A_MOD);
    assign wr_ctrl   = bus_we_i && (bus_addr_i == A_CTRL);
    assign restart_w = wr_ctrl && (bus_wdata_i[1:0] != st_q.ctrl[1:0]);

    ptmr_divider u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (wr_div),
        .div_o   (div_w)
    );

    ptmr_tick_gen u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (st_q.ctrl[2]),
        .code_i    (st_q.ctrl[1:0]),
        .restart_i (restart_w),
        .tick_o    (tick_w)
    );

    always_comb begin
        st_d  = st_q;
        ovf_w = 1'b0;
        if (wr_cnt) begin
            st_d.cnt = bus_wdata_i;
        end else if (tick_w) begin
            if (&st_q.cnt) begin
                st_d.cnt = st_q.modv;
                ovf_w    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (wr_mod) begin
            st_d.modv = bus_wdata_i;
        end
        if (wr_ctrl) begin
            st_d.ctrl = bus_wdata_i[CTRL_W-1:0];
        end
        st_d.flag = ovf_w || (st_q.flag && !irq_clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr_i)
            A_DIV:   bus_rdata_o = div_w;
            A_CNT:   bus_rdata_o = st_q.cnt;
            A_MOD:   bus_rdata_o = st_q.modv;
            A_CTRL:  bus_rdata_o = {{PAD_W{1'b1}}, st_q.ctrl};
            default: bus_rdata_o = 8'hFF;
        endcase
    end

    assign irq_o = st_q.flag;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
    parameter logic [15:0] BASE_ADDR = 16'hFF04
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [15:0] bus_addr_i,
    input logic        bus_we_i,
    input logic [7:0]  bus_rdata_o,
    input logic        irq_clr_i,
    input logic        irq_o,
    input logic        tick_w,
    input logic [7:0]  cnt_q,
    input logic [7:0]  mod_q,
    input logic        en_q
);
    logic cnt_wr, mapped;
    assign cnt_wr = bus_we_i && (bus_addr_i == BASE_ADDR + 16'd1);
    assign mapped = (bus_addr_i >= BASE_ADDR) && (bus_addr_i <= BASE_ADDR + 16'd3);

    p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !irq_clr_i |=> irq_o);

    p_irq_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_clr_i && !(tick_w && !cnt_wr && cnt_q == 8'hFF) |=> !irq_o);

    p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_w && !cnt_wr && cnt_q == 8'hFF |=> irq_o && cnt_q == $past(mod_q));

    p_incr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_w && !cnt_wr && cnt_q != 8'hFF |=> cnt_q == $past(cnt_q) + 8'd1);

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q && !cnt_wr |=> $stable(cnt_q));

    p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mapped |-> bus_rdata_o == 8'hFF);

    p_ctrl_pad_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_addr_i == BASE_ADDR + 16'd3 |-> bus_rdata_o[7:3] == 5'h1F);
endmodule

bind prescaled_timer ptmr_checker #(.BASE_ADDR(BASE_ADDR)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_clr_i   (irq_clr_i),
    .irq_o       (irq_o),
    .tick_w      (tick_w),
    .cnt_q       (st_q.cnt),
    .mod_q       (st_q.modv),
    .en_q        (st_q.ctrl[2])
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
    localparam logic [15:0] A_DIV  = 16'hFF04;
    localparam logic [15:0] A_CNT  = 16'hFF05;
    localparam logic [15:0] A_MOD  = 16'hFF06;
    localparam logic [15:0] A_CTRL = 16'hFF07;
    localparam int NV = 8;
    // {address, write data, expected read-back}
    localparam logic [31:0] VEC [NV] = '{
        {16'hFF06, 8'hA5, 8'hA5},
        {16'hFF05, 8'h3C, 8'h3C},
        {16'hFF00, 8'h12, 8'hFF},
        {16'hFF08, 8'h34, 8'hFF},
        {16'hFF03, 8'h55, 8'hFF},
        {16'hFF07, 8'h00, 8'hF8},
        {16'hFF07, 8'h02, 8'hFA},
        {16'hFF07, 8'hF9, 8'hF9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        we = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        clr = 1'b0;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    prescaled_timer i_prescaled_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_clr_i   (clr),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset state
        rd(A_DIV, v);  chk("R5 div", v, 8'h00);
        rd(A_CNT, v);  chk("R5 cnt", v, 8'h00);
        rd(A_MOD, v);  chk("R5 mod", v, 8'h00);
        rd(A_CTRL, v); chk("R5 ctrl", v, 8'hF8);
        chk("R5 irq", {7'd0, irq}, 8'h00);

        // R8/R9: register vector walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][31:16], VEC[i][15:8]);
            rd(VEC[i][31:16], v);
            chk("R8/R9 vector", v, VEC[i][7:0]);
        end
        rd(A_MOD, v); chk("R8 unmapped write ignored", v, 8'hA5);

        // R1: divider step after 256 cycles, R9 clear
        wr(A_DIV, 8'h5A);
        repeat (255) @(negedge clk);
        rd(A_DIV, v); chk("R1 div before step", v, 8'h00);
        @(negedge clk);
        rd(A_DIV, v); chk("R1 div step", v, 8'h01);

        // R2: all four periods
        for (int c = 0; c < 4; c++) begin
            int per;
            per = (c == 0) ? 1024 : (c == 1) ? 16 : (c == 2) ? 64 : 256;
            wr(A_CTRL, 8'(c ^ 1));
            wr(A_CNT, 8'h20);
            wr(A_CTRL, 8'(4 | c));
            repeat (per - 1) @(negedge clk);
            rd(A_CNT, v); chk("R2 before tick", v, 8'h20);
            @(negedge clk);
            rd(A_CNT, v); chk("R2 R4 tick", v, 8'h21);
        end

        // R3: overflow reload and flag
        wr(A_CTRL, 8'h00);
        wr(A_MOD, 8'h80);
        wr(A_CNT, 8'hFE);
        wr(A_CTRL, 8'h05);
        repeat (31) @(negedge clk);
        rd(A_CNT, v); chk("R4 at top", v, 8'hFF);
        chk("R3 irq before", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rd(A_CNT, v); chk("R3 reload", v, 8'h80);
        chk("R3 irq set", {7'd0, irq}, 8'h01);

        // R6: sticky until cleared
        repeat (20) @(negedge clk);
        chk("R6 sticky", {7'd0, irq}, 8'h01);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R6 cleared", {7'd0, irq}, 8'h00);

        // R6: overflow wins over a simultaneous clear
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, 8'h05);
        wr(A_CNT, 8'hFF);
        repeat (14) @(negedge clk);
        chk("R6 irq low before", {7'd0, irq}, 8'h00);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk("R6 overflow beats clear", {7'd0, irq}, 8'h01);
        rd(A_CNT, v); chk("R3 reload again", v, 8'h80);
        clr = 1'b1; @(negedge clk); clr = 1'b0;

        // R7: disabled counter holds, R1 divider keeps running
        wr(A_CTRL, 8'h01);
        wr(A_CNT, 8'h10);
        wr(A_DIV, 8'h00);
        repeat (300) @(negedge clk);
        rd(A_CNT, v); chk("R7 hold", v, 8'h10);
        rd(A_DIV, v); chk("R1 div while disabled", v, 8'h01);

        // R10: same-code rewrite keeps the accumulator
        wr(A_CTRL, 8'h00);
        wr(A_CNT, 8'h40);
        wr(A_CTRL, 8'h05);
        repeat (8) @(negedge clk);
        wr(A_CTRL, 8'h05);
        repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R10 no restart before", v, 8'h40);
        @(negedge clk);
        rd(A_CNT, v); chk("R10 no restart tick", v, 8'h41);

        // R10: code change while running restarts the accumulator
        repeat (5) @(negedge clk);
        wr(A_CTRL, 8'h07);
        repeat (255) @(negedge clk);
        rd(A_CNT, v); chk("R10 restart before", v, 8'h41);
        @(negedge clk);
        rd(A_CNT, v); chk("R10 restart tick", v, 8'h42);

        finish_run();
    end
endmodule